// File: doc/BRIEF.md
# Switchable Power Domain Sequencer

This block brings a power domain that can be switched off from off to on. Software arms the domain through a small register set, then issues a start command. The sequencer raises a request for external power and stalls. It resumes only after three things hold together: software has set the domain's power-good flag, software has acknowledged the request through the clear register, and the external power-good input is high. It then moves every module inside the domain to the state staged for it, marks the domain as on, and clears its busy and global-control bits.

Each module in the domain has a clock-enable output and an active-low reset output. Both follow the module's current state. A separate register drives an external enable for the short-circuit switch. Power-down sequencing is not part of this block.

Top module: `psd_top`

## Requirements
- R1: After reset every register reads zero, and `pwr_req`, `short_sw_en`, every `mod_clk_en` bit and every `mod_rst_n` bit are low.
- R2: A write to the command register (address 5) with bit 1 set starts the sequence when the sequencer is idle, the domain is off, the control register (address 0) has bit 0 set and has bit 8 clear. One cycle after that write, bit 1 of the transition status register (address 6) reads 1 and bit 0 of the global control register (address 4) reads 1.
- R3: A command write has no effect in any of these cases: bit 1 of the write is clear, control bit 0 is clear, control bit 8 is set, or the domain is already on. The domain counts as on when bits 4:0 of the domain status register (address 1) are nonzero.
- R4: One cycle after the start, bit 1 of the pending register (address 2) and the `pwr_req` output go high.
- R5: A write to the clear register (address 3) with bit 1 set clears pending bit 1 and `pwr_req`. A clear write with bit 1 low changes nothing.
- R6: The sequencer leaves its wait only at a clock edge where control bit 8 is set, pending bit 1 is clear and `pwr_good` is high. One edge later, domain status reads 0x01 and each module takes its staged state. One edge after that, transition status bit 1 and global control bits 4:0 clear.
- R7: Each module has a control register at address 8+i. Bits 1:0 of that register hold the staged next state. Each module also has a status register at address 12+i, whose bits 1:0 show the current state. State 3 enables the clock and releases reset. State 1 enables the clock and holds reset. States 0 and 2 stop the clock and hold reset.
- R8: Bit 0 of the short-switch register (address 7) drives `short_sw_en` and reads back.
- R9: The following bits are writable: control bits 0 and 8, module control bits 1:0 and 8, global control bits 4:0, and short-switch bit 0. All other bits read zero. The clear and command registers read zero. Writes to the status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwr_good | input | 1 | External power-good indication |
| pwr_req | output | 1 | Request for external power |
| short_sw_en | output | 1 | Short-circuit switch enable |
| mod_clk_en | output | NMOD | Per-module clock enable |
| mod_rst_n | output | NMOD | Per-module reset, low holds reset |

## Verification
Register writes take effect at the clock edge that ends the write cycle. Read data is combinational, so a written value is visible in the next cycle. After a start command, busy and global bit 0 are due one edge later and the pending request two edges later. After the wait condition is met at an edge, module states and domain status are due one edge later and the busy bit clears one edge after that. The bench spends exactly one clock per table entry and samples one time unit after the falling edge. Each expected value is therefore placed at the entry whose cycle count matches these latencies.

// File: rtl/psd_pkg.sv
// Shared types and register map for the switchable power domain sequencer.
// Assumes a 4-bit register address space; the module register windows
// start at fixed offsets and hold up to four modules each.
package psd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST_POWER,
        ST_WAIT_GOOD,
        ST_MODULES_ON,
        ST_DONE
    } seq_state_t;

    localparam int unsigned A_DOM_CTRL = 0;
    localparam int unsigned A_DOM_STAT = 1;
    localparam int unsigned A_PEND     = 2;
    localparam int unsigned A_CLR      = 3;
    localparam int unsigned A_GLB      = 4;
    localparam int unsigned A_CMD      = 5;
    localparam int unsigned A_XSTAT    = 6;
    localparam int unsigned A_SCSW     = 7;
    localparam int unsigned A_MOD_CTL  = 8;
    localparam int unsigned A_MOD_STAT = 12;

    localparam int unsigned SW_BIT    = 1;   // domain bit in cmd/status/pend/clr
    localparam int unsigned ON_BIT    = 0;   // request-on bit in domain control
    localparam int unsigned GOOD_BIT  = 8;   // power-good flag position

    localparam logic [1:0] MST_OFF     = 2'd0;
    localparam logic [1:0] MST_SYNCRST = 2'd1;
    localparam logic [1:0] MST_ALTOFF  = 2'd2;
    localparam logic [1:0] MST_EN      = 2'd3;

endpackage

// File: rtl/psd_seq.sv
// Power-up state machine for one switchable domain.
// Assumes the register block qualifies the command write; this module
// only decides when each step happens and emits one-cycle step strobes.
module psd_seq
    import psd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       dom_on,
    input  logic       want_on,
    input  logic       good_flag,
    input  logic       pend,
    input  logic       pwr_good,
    output seq_state_t state,
    output logic       start_p,
    output logic       req_p,
    output logic       apply_p,
    output logic       done_p
);

    seq_state_t state_q, state_d;
    logic       release_ok;

    // Decode step strobes and the wait-exit condition.
    always_comb begin
        start_p    = (state_q == ST_IDLE) && cmd_wr && !dom_on && want_on && !good_flag;
        req_p      = (state_q == ST_REQUEST_POWER);
        apply_p    = (state_q == ST_MODULES_ON);
        done_p     = (state_q == ST_DONE);
        release_ok = good_flag && !pend && pwr_good;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (start_p) state_d = ST_REQUEST_POWER;
            ST_REQUEST_POWER: state_d = ST_WAIT_GOOD;
            ST_WAIT_GOOD:     if (release_ok) state_d = ST_MODULES_ON;
            ST_MODULES_ON:    state_d = ST_DONE;
            ST_DONE:          state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/psd_regs.sv
// Register file of the domain sequencer: domain control and status,
// pending and clear, global control, command and transition status,
// short-switch enable, and per-module control. Read data is combinational.
// Assumes DATA_W > GOOD_BIT and NMOD <= 4.
module psd_regs
    import psd_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NMOD   = 2,
    parameter int unsigned STAT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   start_p,
    input  logic                   req_p,
    input  logic                   apply_p,
    input  logic                   done_p,
    input  logic [NMOD-1:0][1:0]   mod_stat,
    output logic [DATA_W-1:0]      rdata,
    output logic                   want_on,
    output logic                   good_flag,
    output logic                   pend,
    output logic                   busy,
    output logic                   dom_on,
    output logic                   short_sw,
    output logic                   cmd_wr,
    output logic [NMOD-1:0][1:0]   mod_next
);

    logic [STAT_W-1:0] glb_q;
    logic [STAT_W-1:0] dom_stat_q;
    logic [NMOD-1:0]   mod_gate_q;
    logic              hit_ctrl, hit_glb, hit_scsw, clr_hit;

    // Decode writes to each register.
    always_comb begin
        hit_ctrl = wr_en && (addr == ADDR_W'(A_DOM_CTRL));
        hit_glb  = wr_en && (addr == ADDR_W'(A_GLB));
        hit_scsw = wr_en && (addr == ADDR_W'(A_SCSW));
        clr_hit  = wr_en && (addr == ADDR_W'(A_CLR)) && wdata[SW_BIT];
        cmd_wr   = wr_en && (addr == ADDR_W'(A_CMD)) && wdata[SW_BIT];
    end

    // Domain control: on request and power-good flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_on   <= 1'b0;
            good_flag <= 1'b0;
        end else if (hit_ctrl) begin
            want_on   <= wdata[ON_BIT];
            good_flag <= wdata[GOOD_BIT];
        end
    end

    // Pending request: set by the sequencer, cleared by the clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (req_p)   pend <= 1'b1;
        else if (clr_hit) pend <= 1'b0;
    end

    // Transition busy bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy <= 1'b0;
        else if (start_p) busy <= 1'b1;
        else if (done_p)  busy <= 1'b0;
    end

    // Global control: sequencer events take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       glb_q <= '0;
        else if (done_p)  glb_q <= '0;
        else if (start_p) glb_q <= glb_q | STAT_W'(1);
        else if (hit_glb) glb_q <= wdata[STAT_W-1:0];
    end

    // Domain status: takes the on code when the modules are applied.
    always_ff @(posedge clk) begin
        if (!rst_n)       dom_stat_q <= '0;
        else if (apply_p) dom_stat_q <= STAT_W'(1);
    end

    // Short-circuit switch enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        short_sw <= 1'b0;
        else if (hit_scsw) short_sw <= wdata[0];
    end

    // Per-module staged next state and gate flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_next   <= '0;
            mod_gate_q <= '0;
        end else begin
            for (int i = 0; i < NMOD; i++) begin
                if (wr_en && (addr == ADDR_W'(A_MOD_CTL + i))) begin
                    mod_next[i]   <= wdata[1:0];
                    mod_gate_q[i] <= wdata[GOOD_BIT];
                end
            end
        end
    end

    assign dom_on = |dom_stat_q;

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_DOM_CTRL): begin
                rdata[ON_BIT]   = want_on;
                rdata[GOOD_BIT] = good_flag;
            end
            ADDR_W'(A_DOM_STAT): rdata[STAT_W-1:0] = dom_stat_q;
            ADDR_W'(A_PEND):     rdata[SW_BIT]     = pend;
            ADDR_W'(A_GLB):      rdata[STAT_W-1:0] = glb_q;
            ADDR_W'(A_XSTAT):    rdata[SW_BIT]     = busy;
            ADDR_W'(A_SCSW):     rdata[0]          = short_sw;
            default:             rdata = '0;
        endcase
        for (int i = 0; i < NMOD; i++) begin
            if (addr == ADDR_W'(A_MOD_CTL + i)) begin
                rdata[1:0]      = mod_next[i];
                rdata[GOOD_BIT] = mod_gate_q[i];
            end
            if (addr == ADDR_W'(A_MOD_STAT + i)) begin
                rdata[1:0] = mod_stat[i];
            end
        end
    end

endmodule

// File: rtl/psd_modctl.sv
// One module slot inside the domain: holds the current module state,
// loads the staged state on the apply strobe, and derives clock enable
// and reset release from it. Assumes apply is a single-cycle strobe.
module psd_modctl
    import psd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply,
    input  logic [1:0] next_state,
    output logic [1:0] cur_state,
    output logic       clk_en,
    output logic       rst_rel
);

    // Current module state.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_state <= MST_OFF;
        else if (apply) cur_state <= next_state;
    end

    // Clock runs in enable and sync-reset; reset released only in enable.
    always_comb begin
        clk_en  = (cur_state == MST_EN) || (cur_state == MST_SYNCRST);
        rst_rel = (cur_state == MST_EN);
    end

endmodule

// File: rtl/psd_top.sv
// Switchable power domain sequencer top: ties the register file, the
// power-up state machine and one module slot per domain module.
// Assumes a single synchronous clock and synchronous active-low reset.
module psd_top
    import psd_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NMOD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pwr_good,
    output logic              pwr_req,
    output logic              short_sw_en,
    output logic [NMOD-1:0]   mod_clk_en,
    output logic [NMOD-1:0]   mod_rst_n
);

    localparam int unsigned STAT_W = 5;

    seq_state_t            state;
    logic                  start_p, req_p, apply_p, done_p;
    logic                  want_on, good_flag, pend, busy, dom_on, short_sw, cmd_wr;
    logic [NMOD-1:0][1:0]  mod_next;
    logic [NMOD-1:0][1:0]  mod_stat;

    psd_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NMOD   (NMOD),
        .STAT_W (STAT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .start_p   (start_p),
        .req_p     (req_p),
        .apply_p   (apply_p),
        .done_p    (done_p),
        .mod_stat  (mod_stat),
        .rdata     (rdata),
        .want_on   (want_on),
        .good_flag (good_flag),
        .pend      (pend),
        .busy      (busy),
        .dom_on    (dom_on),
        .short_sw  (short_sw),
        .cmd_wr    (cmd_wr),
        .mod_next  (mod_next)
    );

    psd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .dom_on    (dom_on),
        .want_on   (want_on),
        .good_flag (good_flag),
        .pend      (pend),
        .pwr_good  (pwr_good),
        .state     (state),
        .start_p   (start_p),
        .req_p     (req_p),
        .apply_p   (apply_p),
        .done_p    (done_p)
    );

    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        psd_modctl u_mod (
            .clk        (clk),
            .rst_n      (rst_n),
            .apply      (apply_p),
            .next_state (mod_next[g]),
            .cur_state  (mod_stat[g]),
            .clk_en     (mod_clk_en[g]),
            .rst_rel    (mod_rst_n[g])
        );
    end

    assign pwr_req     = pend;
    assign short_sw_en = short_sw;

endmodule

// File: rtl/psd_checker.sv
// Temporal checks for psd_top, attached through bind. Observes ports
// plus the busy and domain-on state that separate logic produces.
module psd_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NMOD   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              pwr_good,
    input logic              pwr_req,
    input logic              short_sw_en,
    input logic [NMOD-1:0]   mod_clk_en,
    input logic [NMOD-1:0]   mod_rst_n,
    input logic              busy,
    input logic              dom_on
);

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == ADDR_W'(5) && wdata[1])); // R2

    AST_REQ_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |-> busy); // R4

    AST_REQ_FALL_BY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_req) |-> $past(wr_en && addr == ADDR_W'(3) && wdata[1])); // R5

    AST_ON_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_on) |-> $past(pwr_good, 2)); // R6

    AST_DONE_LEAVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> dom_on); // R6

    AST_ON_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        dom_on |=> dom_on); // R6

    AST_SW_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(short_sw_en) |-> $past(wr_en && addr == ADDR_W'(7))); // R8

    for (genvar g = 0; g < NMOD; g++) begin : g_mod_chk
        AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
            mod_rst_n[g] |-> mod_clk_en[g]); // R7
    end

endmodule

bind psd_top psd_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NMOD   (NMOD)
) u_psd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .pwr_good    (pwr_good),
    .pwr_req     (pwr_req),
    .short_sw_en (short_sw_en),
    .mod_clk_en  (mod_clk_en),
    .mod_rst_n   (mod_rst_n),
    .busy        (busy),
    .dom_on      (dom_on)
);

// File: tb/psd_top_tb.sv
module psd_top_tb_top;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int NMOD   = 2;
    localparam int NVEC   = 43;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              pwr_good = 1'b0;
    logic              pwr_req;
    logic              short_sw_en;
    logic [NMOD-1:0]   mod_clk_en;
    logic [NMOD-1:0]   mod_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    psd_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NMOD(NMOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwr_good(pwr_good), .pwr_req(pwr_req),
        .short_sw_en(short_sw_en), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
    );

    // Entry: {write, pwr_good, req tag, addr, data, expected read}
    // One clock per entry. Reads compare rdata; writes check nothing.
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1,1'b0,4'd3, 4'd0, 16'h0101,16'h0000}, // 0  R3 ctrl on+good
        {1'b1,1'b0,4'd3, 4'd5, 16'h0002,16'h0000}, // 1  R3 cmd blocked by good
        {1'b0,1'b0,4'd3, 4'd6, 16'h0000,16'h0000}, // 2  R3
        {1'b1,1'b0,4'd3, 4'd0, 16'h0000,16'h0000}, // 3  R3 ctrl off
        {1'b1,1'b0,4'd3, 4'd5, 16'h0002,16'h0000}, // 4  R3 cmd blocked by off
        {1'b0,1'b0,4'd3, 4'd6, 16'h0000,16'h0000}, // 5  R3
        {1'b1,1'b0,4'd9, 4'd0, 16'hFEFF,16'h0000}, // 6  R9 masked write
        {1'b0,1'b0,4'd9, 4'd0, 16'h0000,16'h0001}, // 7  R9
        {1'b1,1'b0,4'd9, 4'd8, 16'hFEFF,16'h0000}, // 8  R9 module 0 -> 3
        {1'b0,1'b0,4'd9, 4'd8, 16'h0000,16'h0003}, // 9  R9
        {1'b1,1'b0,4'd7, 4'd9, 16'h0001,16'h0000}, // 10 R7 module 1 -> 1
        {1'b1,1'b0,4'd3, 4'd5, 16'h0001,16'h0000}, // 11 R3 cmd without bit 1
        {1'b0,1'b0,4'd3, 4'd6, 16'h0000,16'h0000}, // 12 R3
        {1'b1,1'b0,4'd2, 4'd5, 16'h0002,16'h0000}, // 13 R2 start
        {1'b0,1'b0,4'd2, 4'd6, 16'h0000,16'h0002}, // 14 R2 busy
        {1'b0,1'b0,4'd2, 4'd4, 16'h0000,16'h0001}, // 15 R2 global bit 0
        {1'b0,1'b0,4'd4, 4'd2, 16'h0000,16'h0002}, // 16 R4 pending
        {1'b1,1'b0,4'd5, 4'd3, 16'h0001,16'h0000}, // 17 R5 clear without bit 1
        {1'b0,1'b0,4'd5, 4'd2, 16'h0000,16'h0002}, // 18 R5
        {1'b1,1'b0,4'd6, 4'd0, 16'h0101,16'h0000}, // 19 R6 good flag
        {1'b1,1'b0,4'd5, 4'd3, 16'h0002,16'h0000}, // 20 R5 clear
        {1'b0,1'b0,4'd5, 4'd2, 16'h0000,16'h0000}, // 21 R5
        {1'b0,1'b0,4'd6, 4'd6, 16'h0000,16'h0002}, // 22 R6 still waiting
        {1'b0,1'b0,4'd6, 4'd1, 16'h0000,16'h0000}, // 23 R6
        {1'b0,1'b1,4'd6, 4'd1, 16'h0000,16'h0000}, // 24 R6 power good
        {1'b0,1'b1,4'd6, 4'd1, 16'h0000,16'h0000}, // 25 R6 modules-on cycle
        {1'b0,1'b1,4'd6, 4'd6, 16'h0000,16'h0002}, // 26 R6 done cycle
        {1'b0,1'b1,4'd6, 4'd6, 16'h0000,16'h0000}, // 27 R6
        {1'b0,1'b1,4'd6, 4'd1, 16'h0000,16'h0001}, // 28 R6
        {1'b0,1'b1,4'd6, 4'd4, 16'h0000,16'h0000}, // 29 R6
        {1'b0,1'b1,4'd7, 4'd12,16'h0000,16'h0003}, // 30 R7
        {1'b0,1'b1,4'd7, 4'd13,16'h0000,16'h0001}, // 31 R7
        {1'b1,1'b1,4'd3, 4'd5, 16'h0002,16'h0000}, // 32 R3 cmd while on
        {1'b0,1'b1,4'd3, 4'd6, 16'h0000,16'h0000}, // 33 R3
        {1'b0,1'b1,4'd3, 4'd2, 16'h0000,16'h0000}, // 34 R3
        {1'b1,1'b1,4'd8, 4'd7, 16'h0001,16'h0000}, // 35 R8
        {1'b0,1'b1,4'd8, 4'd7, 16'h0000,16'h0001}, // 36 R8
        {1'b1,1'b1,4'd9, 4'd1, 16'h0000,16'h0000}, // 37 R9 status write
        {1'b0,1'b1,4'd9, 4'd1, 16'h0000,16'h0001}, // 38 R9
        {1'b0,1'b1,4'd9, 4'd5, 16'h0000,16'h0000}, // 39 R9
        {1'b0,1'b1,4'd9, 4'd3, 16'h0000,16'h0000}, // 40 R9
        {1'b1,1'b1,4'd9, 4'd4, 16'hFFFF,16'h0000}, // 41 R9
        {1'b0,1'b1,4'd9, 4'd4, 16'h0000,16'h001F}  // 42 R9
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        wr_en = 1'b0; addr = a; wdata = '0;
        #1 check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic reset_all();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state();
        #1;
        check("R1 pwr_req", 16'(pwr_req), 16'h0);
        check("R1 short_sw_en", 16'(short_sw_en), 16'h0);
        check("R1 mod_clk_en", 16'(mod_clk_en), 16'h0);
        check("R1 mod_rst_n", 16'(mod_rst_n), 16'h0);
        for (int a = 0; a < 16; a++) rd("R1 register", 4'(a), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        // Table walk: one clock per entry.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_en    = VEC[i][41];
            pwr_good = VEC[i][40];
            addr     = VEC[i][35:32];
            wdata    = VEC[i][31:16];
            #1;
            if (!VEC[i][41])
                check($sformatf("R%0d entry %0d", VEC[i][39:36], i), rdata, VEC[i][15:0]);
            if (i == 16) check("R4 pwr_req high", 16'(pwr_req), 16'h1);
        end
        idle(1);
        #1;
        check("R7 clocks after power-up", 16'(mod_clk_en), 16'h3);
        check("R7 resets after power-up", 16'(mod_rst_n), 16'h1);
        check("R8 short_sw_en", 16'(short_sw_en), 16'h1);
        check("R5 pwr_req low", 16'(pwr_req), 16'h0);

        // Second power-up: module 0 staged to state 2, external power already good.
        reset_all();
        check_reset_state();
        pwr_good = 1'b1;
        wr(4'd8, 16'h0002);
        wr(4'd0, 16'h0001);
        wr(4'd5, 16'h0002);
        idle(2);
        #1 check("R4 pwr_req after start", 16'(pwr_req), 16'h1);
        wr(4'd0, 16'h0101);
        idle(3);
        rd("R6 waits while pending", 4'd6, 16'h0002);
        rd("R6 domain still off", 4'd1, 16'h0000);
        wr(4'd3, 16'h0002);
        idle(4);
        rd("R7 module 0 state 2", 4'd12, 16'h0002);
        rd("R6 domain on", 4'd1, 16'h0001);
        rd("R6 busy cleared", 4'd6, 16'h0000);
        #1;
        check("R7 state 2 clock off", 16'(mod_clk_en), 16'h0);
        check("R7 state 2 reset held", 16'(mod_rst_n), 16'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule